// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table

This block holds the memory-mapped vector table and the pending-word image of a 128-trigger interrupt unit. It is reached through a simple request/acknowledge register port with a 12-bit byte address. Every trigger owns a 16-byte slot in the upper half of the address space. Only two words of each slot hold state: a 5-bit vector number and a one-bit entry mask. The two message-address words are not stored, because address generation happens elsewhere.

The entry mask is not a private copy. It is the same flop as the trigger's bit in the group interrupt mask. The group-side mask logic updates it through set and clear strobes, and a table write updates it through the word-3 bit. Both views therefore always agree. Table slots are packed by flat trigger number. The pending image and the mask vector are group-aligned: trigger t sits in group t/32 at bit t%32. A 3-bit traffic-class register is also held here. The block outputs every trigger's vector number, the 128-bit mask and the traffic class, for use by the message engine.

The access controller has two states. In IDLE a request is accepted (transition ACCEPT), and any write takes effect at that clock edge. In RESP the acknowledge is high for one cycle with the read data, and the controller then returns to IDLE (transition COMPLETE). A request presented while in RESP is not accepted.

Top module: `msix_vector_table`

## Requirements
- R1: After reset every mask bit is 1, every vector number is 0, the traffic class is 0 and the acknowledge is low.
- R2: A request seen while the acknowledge is low is accepted at that clock edge. The acknowledge is high in the next cycle only, carrying the read data, and any write takes effect at the accepting edge.
- R3: An address with bit 11 set selects the table. Bits 10:4 give the trigger number t, bits 3:2 give the word and bits 1:0 give the byte. Trigger t's outputs are vec_o[5t+4:5t] and mask_o[t], which is group t/32, bit t%32.
- R4: Word 2 of a slot (byte offset 8) reads and writes the 5-bit vector number in bits 4:0. Bits 31:5 read 0.
- R5: Word 3 of a slot (byte offset 12) bit 0 is the trigger's mask bit, mask_o[t]. A read returns it, a write updates it, and bits 31:1 read 0.
- R6: Words 0 and 1 of a slot (byte offsets 0 and 4) read 0, and writes to them change no output.
- R7: A write takes effect only if byte strobe 0 (wstrb_i[0]) is set. All implemented bits lie in byte 0.
- R8: Addresses 0x3F0, 0x3F4, 0x3F8 and 0x3FC read cause_i[32g+31:32g] for group g = 0..3, sampled at acceptance.
- R9: Writes to the pending image change no output and no stored state.
- R10: Address 0x3E0 holds a 3-bit traffic class in bits 2:0, readable, writable and driven on tc_o. It resets to 0.
- R11: mask_set_i[t] sets mask_o[t] and mask_clr_i[t] clears it on the next cycle. Set wins over clear, and both win over a table write in the same cycle.
- R12: Any other address reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wstrb_i | input | 4 | Write byte strobes |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access completion, one cycle |
| rdata_o | output | 32 | Read data, valid with ack_o |
| cause_i | input | 128 | Group-aligned cause bits for the pending image |
| mask_set_i | input | 128 | Group-side mask set strobes |
| mask_clr_i | input | 128 | Group-side mask clear strobes |
| vec_o | output | 640 | Per-trigger 5-bit vector numbers, packed by trigger |
| mask_o | output | 128 | Per-trigger mask, shared with the group mask |
| tc_o | output | 3 | Traffic class for message writes |

## Verification
The assertions check the following on every cycle: the one-cycle acknowledge after an accepted request, the reset values, the next-cycle effect and priority of mask set and clear, and that vectors and traffic class stay stable when no write is accepted. They also check that writes to unstored words, to the pending image, to unmapped space or without byte strobe 0 leave the outputs unchanged. Only the bench scenarios show the address decode itself: the packing of trigger slots by flat index, the group-aligned pending words, the exact read values and the zero bits of every word.

// File: rtl/msix_tbl_pkg.sv
package msix_tbl_pkg;
    typedef enum logic [1:0] {
        RG_NONE  = 2'd0,
        RG_ENTRY = 2'd1,
        RG_PBA   = 2'd2,
        RG_TC    = 2'd3
    } region_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    localparam logic [1:0] WORD_VEC  = 2'd2;
    localparam logic [1:0] WORD_CTRL = 2'd3;
endpackage

// File: rtl/msix_addr_decode.sv
module msix_addr_decode
    import msix_tbl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int ENT_W = 7,
    parameter int GSEL_W = 2,
    parameter logic [ADDR_W-1:0] PBA_BASE = 12'h3F0,
    parameter logic [ADDR_W-1:0] TC_ADDR = 12'h3E0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           region_o,
    output logic [ENT_W-1:0]  entry_o,
    output logic [1:0]        word_o,
    output logic [GSEL_W-1:0] grp_o
);
    logic unused_byte;
    assign unused_byte = ^addr_i[1:0];

    always_comb begin
        if (addr_i[ADDR_W-1])
            region_o = RG_ENTRY;
        else if (addr_i[ADDR_W-1:2+GSEL_W] == PBA_BASE[ADDR_W-1:2+GSEL_W])
            region_o = RG_PBA;
        else if (addr_i[ADDR_W-1:2] == TC_ADDR[ADDR_W-1:2])
            region_o = RG_TC;
        else
            region_o = RG_NONE;
    end

    assign entry_o = addr_i[4 +: ENT_W];
    assign word_o  = addr_i[3:2];
    assign grp_o   = addr_i[2 +: GSEL_W];
endmodule

// File: rtl/msix_entry_store.sv
module msix_entry_store #(
    parameter int NUM_TRIG = 128,
    parameter int VEC_W = 5,
    localparam int ENT_W = $clog2(NUM_TRIG)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_vec_i,
    input  logic                      wr_mask_i,
    input  logic [ENT_W-1:0]          entry_i,
    input  logic [VEC_W-1:0]          wvec_i,
    input  logic                      wmask_i,
    input  logic [NUM_TRIG-1:0]       mask_set_i,
    input  logic [NUM_TRIG-1:0]       mask_clr_i,
    output logic [VEC_W-1:0]          rd_vec_o,
    output logic                      rd_mask_o,
    output logic [NUM_TRIG*VEC_W-1:0] vec_o,
    output logic [NUM_TRIG-1:0]       mask_o
);
    logic [VEC_W-1:0]    vec_q [NUM_TRIG];
    logic [NUM_TRIG-1:0] mask_q;

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_slot
        logic hit;
        assign hit = (entry_i == ENT_W'(t));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
                vec_q[t] <= '0;
            else if (wr_vec_i && hit)
                vec_q[t] <= wvec_i;
        end

        // group-side set beats clear, both beat a table write
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
                mask_q[t] <= 1'b1;
            else if (mask_set_i[t])
                mask_q[t] <= 1'b1;
            else if (mask_clr_i[t])
                mask_q[t] <= 1'b0;
            else if (wr_mask_i && hit)
                mask_q[t] <= wmask_i;
        end

        assign vec_o[t*VEC_W +: VEC_W] = vec_q[t];
    end

    assign mask_o    = mask_q;
    assign rd_vec_o  = vec_q[entry_i];
    assign rd_mask_o = mask_q[entry_i];
endmodule

// File: rtl/msix_vector_table.sv
module msix_vector_table
    import msix_tbl_pkg::*;
#(
    parameter int NUM_TRIG = 128,
    parameter int GRP_W = 32,
    parameter int VEC_W = 5,
    parameter int TC_W = 3,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int NUM_GRP = NUM_TRIG / GRP_W,
    localparam int ENT_W = $clog2(NUM_TRIG),
    localparam int GSEL_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      req_i,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W/8-1:0]       wstrb_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic                      ack_o,
    output logic [DATA_W-1:0]         rdata_o,
    input  logic [NUM_TRIG-1:0]       cause_i,
    input  logic [NUM_TRIG-1:0]       mask_set_i,
    input  logic [NUM_TRIG-1:0]       mask_clr_i,
    output logic [NUM_TRIG*VEC_W-1:0] vec_o,
    output logic [NUM_TRIG-1:0]       mask_o,
    output logic [TC_W-1:0]           tc_o
);
    bus_state_e state_q, state_d;
    region_e    region;
    logic [ENT_W-1:0]  entry;
    logic [1:0]        word;
    logic [GSEL_W-1:0] grp;
    logic accept, wr_ok;
    logic wr_vec, wr_mask, wr_tc;
    logic [VEC_W-1:0] rd_vec;
    logic rd_mask;
    logic [TC_W-1:0] tc_q;
    logic [DATA_W-1:0] rd_mux, rdata_q;
    logic [GRP_W-1:0] cause_w [NUM_GRP];

    logic unused_in;
    assign unused_in = ^{wstrb_i[DATA_W/8-1:1], wdata_i[DATA_W-1:VEC_W]};

    msix_addr_decode #(
        .ADDR_W(ADDR_W), .ENT_W(ENT_W), .GSEL_W(GSEL_W)
    ) u_dec (
        .addr_i(addr_i), .region_o(region), .entry_o(entry),
        .word_o(word), .grp_o(grp)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // transitions: ACCEPT (IDLE->RESP), COMPLETE (RESP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        ack_o  = 1'b0;
        accept = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = req_i;
            ST_RESP: ack_o  = 1'b1;
        endcase
    end

    assign wr_ok   = accept && we_i && wstrb_i[0];
    assign wr_vec  = wr_ok && (region == RG_ENTRY) && (word == WORD_VEC);
    assign wr_mask = wr_ok && (region == RG_ENTRY) && (word == WORD_CTRL);
    assign wr_tc   = wr_ok && (region == RG_TC);

    msix_entry_store #(.NUM_TRIG(NUM_TRIG), .VEC_W(VEC_W)) u_store (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_vec_i(wr_vec), .wr_mask_i(wr_mask), .entry_i(entry),
        .wvec_i(wdata_i[VEC_W-1:0]), .wmask_i(wdata_i[0]),
        .mask_set_i(mask_set_i), .mask_clr_i(mask_clr_i),
        .rd_vec_o(rd_vec), .rd_mask_o(rd_mask),
        .vec_o(vec_o), .mask_o(mask_o)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    tc_q <= '0;
        else if (wr_tc) tc_q <= wdata_i[TC_W-1:0];
    end
    assign tc_o = tc_q;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign cause_w[g] = cause_i[g*GRP_W +: GRP_W];
    end

    always_comb begin
        rd_mux = '0;
        unique case (region)
            RG_ENTRY: begin
                if (word == WORD_VEC)       rd_mux[VEC_W-1:0] = rd_vec;
                else if (word == WORD_CTRL) rd_mux[0] = rd_mask;
            end
            RG_PBA:  rd_mux[GRP_W-1:0] = cause_w[grp];
            RG_TC:   rd_mux[TC_W-1:0] = tc_q;
            RG_NONE: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                rdata_q <= '0;
        else if (accept && !we_i)   rdata_q <= rd_mux;
        else if (accept)            rdata_q <= '0;
    end
    assign rdata_o = rdata_q;
endmodule

// File: rtl/msix_tbl_checker.sv
module msix_tbl_checker #(
    parameter int NUM_TRIG = 128,
    parameter int VEC_W = 5,
    parameter int TC_W = 3,
    parameter int ADDR_W = 12
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      req_i,
    input logic                      we_i,
    input logic [ADDR_W-1:0]         addr_i,
    input logic [3:0]                wstrb_i,
    input logic                      ack_o,
    input logic [NUM_TRIG-1:0]       mask_set_i,
    input logic [NUM_TRIG-1:0]       mask_clr_i,
    input logic [NUM_TRIG*VEC_W-1:0] vec_o,
    input logic [NUM_TRIG-1:0]       mask_o,
    input logic [TC_W-1:0]           tc_o
);
    logic acc, wr_acc, grp_idle;
    assign acc      = req_i && !ack_o;
    assign wr_acc   = acc && we_i;
    assign grp_idle = (mask_set_i == '0) && (mask_clr_i == '0);

    assert_reset_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (mask_o == '1 && vec_o == '0 && tc_o == '0 && !ack_o));

    assert_ack_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc |=> ack_o);

    assert_ack_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o);

    assert_quiet_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_acc |=> ($stable(vec_o) && $stable(tc_o)));

    assert_mask_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_acc && grp_idle) |=> $stable(mask_o));

    assert_unstored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_acc && addr_i[ADDR_W-1] && !addr_i[3] && grp_idle)
        |=> ($stable(vec_o) && $stable(tc_o) && $stable(mask_o)));

    assert_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_acc && !wstrb_i[0] && grp_idle)
        |=> ($stable(vec_o) && $stable(tc_o) && $stable(mask_o)));

    assert_pba_ro_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_acc && addr_i[ADDR_W-1:4] == 8'h3F && grp_idle)
        |=> ($stable(vec_o) && $stable(tc_o) && $stable(mask_o)));

    assert_mask_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_set_i != '0) |=> ((mask_o & $past(mask_set_i)) == $past(mask_set_i)));

    assert_mask_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mask_clr_i & ~mask_set_i) != '0)
        |=> ((mask_o & $past(mask_clr_i & ~mask_set_i)) == '0));

    assert_unmapped_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_acc && !addr_i[ADDR_W-1] && addr_i[ADDR_W-1:4] != 8'h3F
         && addr_i[ADDR_W-1:4] != 8'h3E && grp_idle)
        |=> ($stable(vec_o) && $stable(tc_o) && $stable(mask_o)));
endmodule

bind msix_vector_table msix_tbl_checker #(
    .NUM_TRIG(NUM_TRIG), .VEC_W(VEC_W), .TC_W(TC_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wstrb_i(wstrb_i), .ack_o(ack_o),
    .mask_set_i(mask_set_i), .mask_clr_i(mask_clr_i),
    .vec_o(vec_o), .mask_o(mask_o), .tc_o(tc_o)
);

// File: tb/msix_vector_table_bench.sv
module msix_vector_table_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 128;
    localparam int VW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [3:0] strb = '0;
    logic [31:0] wd = '0;
    logic ack;
    logic [31:0] rd;
    logic [NT-1:0] cause = {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000};
    logic [NT-1:0] mset = '0, mclr = '0;
    logic [NT*VW-1:0] vec;
    logic [NT-1:0] mask;
    logic [2:0] tc;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msix_vector_table u_msix_vector_table (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wstrb_i(strb), .wdata_i(wd), .ack_o(ack), .rdata_o(rd),
        .cause_i(cause), .mask_set_i(mset), .mask_clr_i(mclr),
        .vec_o(vec), .mask_o(mask), .tc_o(tc)
    );

    typedef struct packed {
        logic        w;
        logic [11:0] a;
        logic [3:0]  s;
        logic [31:0] d;
        logic [31:0] e;
        logic [7:0]  r;
    } row_t;

    localparam int NROW = 24;
    localparam row_t TBL [NROW] = '{
        '{1'b0, 12'h808, 4'h0, 32'h0,          32'h0,          8'd4},  // R4 reset vector
        '{1'b0, 12'h80C, 4'h0, 32'h0,          32'h1,          8'd5},  // R5 mask reset
        '{1'b1, 12'h808, 4'hF, 32'hFFFF_FFF5,  32'h0,          8'd4},
        '{1'b0, 12'h808, 4'h0, 32'h0,          32'h15,         8'd4},  // R4 upper bits zero
        '{1'b1, 12'h8FC, 4'h1, 32'h0,          32'h0,          8'd5},
        '{1'b0, 12'h8FC, 4'h0, 32'h0,          32'h0,          8'd5},  // R5
        '{1'b1, 12'hFF8, 4'h1, 32'h1F,         32'h0,          8'd3},
        '{1'b0, 12'hFF8, 4'h0, 32'h0,          32'h1F,         8'd3},  // R3 last slot
        '{1'b1, 12'hA08, 4'hE, 32'h7,          32'h0,          8'd7},
        '{1'b0, 12'hA08, 4'h0, 32'h0,          32'h0,          8'd7},  // R7
        '{1'b1, 12'h800, 4'hF, 32'hFFFF_FFFF,  32'h0,          8'd6},
        '{1'b0, 12'h800, 4'h0, 32'h0,          32'h0,          8'd6},  // R6
        '{1'b1, 12'h804, 4'hF, 32'hFFFF_FFFF,  32'h0,          8'd6},
        '{1'b0, 12'h804, 4'h0, 32'h0,          32'h0,          8'd6},  // R6
        '{1'b1, 12'h3E0, 4'h1, 32'hFF,         32'h0,          8'd10},
        '{1'b0, 12'h3E0, 4'h0, 32'h0,          32'h7,          8'd10}, // R10
        '{1'b0, 12'h3E4, 4'h0, 32'h0,          32'h0,          8'd12}, // R12
        '{1'b1, 12'h100, 4'hF, 32'hFFFF_FFFF,  32'h0,          8'd12},
        '{1'b0, 12'h100, 4'h0, 32'h0,          32'h0,          8'd12}, // R12
        '{1'b1, 12'h3F4, 4'hF, 32'h0,          32'h0,          8'd9},
        '{1'b0, 12'h3F4, 4'h0, 32'h0,          32'hBBBB_0001,  8'd9},  // R9
        '{1'b0, 12'h3F0, 4'h0, 32'h0,          32'hAAAA_0000,  8'd8},  // R8
        '{1'b0, 12'h3FC, 4'h0, 32'h0,          32'hDDDD_0003,  8'd8},  // R8
        '{1'b0, 12'h808, 4'h0, 32'h0,          32'h15,         8'd6}   // R6 slot intact
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a, input logic [3:0] s,
                          input logic [31:0] d, output logic [31:0] r);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; strb = s; wd = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        check("R2 ack after accept", 32'(ack), 32'h1);
        r = rd;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 mask reset", 32'(mask == '1), 32'h1);
        check("R1 vec reset", 32'(vec == '0), 32'h1);
        check("R1 tc reset", 32'(tc), 32'h0);
        check("R1 ack reset", 32'(ack), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NROW; i++) begin
            access(TBL[i].w, TBL[i].a, TBL[i].s, TBL[i].d, r);
            if (!TBL[i].w)
                check($sformatf("R%0d row %0d", TBL[i].r, i), r, TBL[i].e);
        end

        // R2 acknowledge lasts one cycle
        @(negedge clk);
        check("R2 ack single", 32'(ack), 32'h0);

        // outputs reflect table writes
        check("R5 mask_o[15]", 32'(mask[15]), 32'h0);
        check("R3 vec_o slot127", 32'(vec[127*VW +: VW]), 32'h1F);
        check("R10 tc_o", 32'(tc), 32'h7);
        check("R7 vec_o slot32", 32'(vec[32*VW +: VW]), 32'h0);

        // R3 flat slot 33 = group 1 bit 1
        access(1'b1, 12'hA18, 4'h1, 32'h9, r);
        check("R3 vec_o slot33", 32'(vec[33*VW +: VW]), 32'h9);
        access(1'b1, 12'hA1C, 4'h1, 32'h0, r);
        check("R3 group1 bit1 mask", 32'(mask[1*32+1]), 32'h0);
        check("R3 neighbour mask", 32'(mask[32]), 32'h1);

        // R11 group-side clear then visible through table
        @(negedge clk);
        mclr[40] = 1'b1;
        @(negedge clk);
        mclr[40] = 1'b0;
        check("R11 clear strobe", 32'(mask[40]), 32'h0);
        access(1'b0, 12'hA8C, 4'h0, 32'h0, r);
        check("R5 alias read", r, 32'h0);

        // R11 set beats clear
        @(negedge clk);
        mset[40] = 1'b1; mclr[40] = 1'b1;
        @(negedge clk);
        mset[40] = 1'b0; mclr[40] = 1'b0;
        check("R11 set over clear", 32'(mask[40]), 32'h1);

        // R11 set beats a table write in the same cycle
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 12'hA9C; strb = 4'h1; wd = 32'h0;
        mset[41] = 1'b1;
        @(negedge clk);
        req = 1'b0; we = 1'b0; mset[41] = 1'b0;
        check("R11 set over write", 32'(mask[41]), 32'h1);

        // R5 table write re-sets a mask bit
        access(1'b1, 12'h8FC, 4'h1, 32'h1, r);
        check("R5 write one", 32'(mask[15]), 32'h1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule